// File: doc/BRIEF.md
# Four-bit character display sequencer

This block drives a character display controller over a nibble-wide parallel bus: four data lines, a register-select line and an enable strobe. After reset it waits a start-up interval, then runs a fixed power-on sequence on its own. The first step is a single nibble `0x3`, sent as a command while the display may still expect a byte-wide bus. It then sends three full commands: `0x28` (nibble bus, two lines), `0x0C` (display on, cursor off) and `0x06` (address increments after each write).

Once that sequence is done the block raises `in_ready`. It accepts one byte per valid/ready handshake, together with a flag that marks it as a command or as character data. Each byte leaves as two nibbles, upper half first, and each nibble gets its own enable pulse. The display samples a nibble when the enable falls. The block never reads the display's busy flag. Fixed, parameterized waits replace it: a long one after the single start nibble and a shorter one after every byte.

Top module: `lcd4_seq`

## Requirements
- R1: While reset is held and directly after it, `lcd_e` is 0 and `in_ready` is 0. No strobe appears before `START_CYC` cycles have passed.
- R2: The power-on sequence sends exactly seven nibbles with `lcd_rs` = 0, in the order 0x3, 0x2, 0x8, 0x0, 0xC, 0x0, 0x6. `in_ready` stays 0 until the sequence ends.
- R3: A byte accepted through the handshake is sent as its bits [7:4] on `lcd_d` first, then its bits [3:0].
- R4: `lcd_rs` equals `in_is_data` as it was at acceptance (0 = command, 1 = character data) for both nibbles of the byte.
- R5: Before every rising edge of `lcd_e`, `lcd_d` and `lcd_rs` have held their values with `lcd_e` low for at least `SETUP_CYC` cycles.
- R6: `lcd_e` stays high for at least `PULSE_CYC` cycles. `lcd_d` and `lcd_rs` do not change while it is high, nor on the clock edge where it falls.
- R7: After the single start nibble falls, at least `BOOT_WAIT_CYC` cycles pass before the next rising edge of `lcd_e`.
- R8: After the second nibble of a byte falls, `in_ready` stays 0 for at least `WAIT_CYC` cycles. `in_ready` is never 1 while `lcd_e` is 1.
- R9: `in_valid` has no effect while `in_ready` is 0. Such a byte never reaches `lcd_d`.
- R10: A byte is taken on the clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_byte | input | 8 | Byte to send |
| in_is_data | input | 1 | 1 = character data, 0 = command |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| lcd_d | output | 4 | Data nibble to the display |
| lcd_rs | output | 1 | Register select |
| lcd_e | output | 1 | Enable strobe; the display latches on its falling edge |

## Verification
A corrupted nibble index or step counter shows up at the next falling edge of `lcd_e`. The value latched there is either the wrong half of the byte or the wrong power-on command. A wrong wait or pulse counter shows up as an enable pulse or setup window shorter than its parameter, or as `in_ready` returning too early; both are visible within one byte time. A handshake fault, such as a byte taken while busy or a byte lost, shows up as an extra or missing nibble against the stream the bench expects. That shortfall is confirmed when the bench drains after its last byte.

// File: rtl/lcd4_seq.sv
module lcd4_seq #(
  parameter int SETUP_CYC     = 4,
  parameter int PULSE_CYC     = 24,
  parameter int WAIT_CYC      = 2500,
  parameter int BOOT_WAIT_CYC = 250000,
  parameter int START_CYC     = 2000000
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_byte,
  input  logic       in_is_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [3:0] lcd_d,
  output logic       lcd_rs,
  output logic       lcd_e
);
  localparam int M1   = SETUP_CYC > PULSE_CYC ? SETUP_CYC : PULSE_CYC;
  localparam int M2   = WAIT_CYC > BOOT_WAIT_CYC ? WAIT_CYC : BOOT_WAIT_CYC;
  localparam int M3   = M1 > M2 ? M1 : M2;
  localparam int MAXC = M3 > START_CYC ? M3 : START_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_WAIT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [7:0]    cur;
  logic          rs_q, lo, single;
  logic [2:0]    step;

  function automatic logic [7:0] boot_byte(input logic [1:0] i);
    case (i)
      2'd0:    return 8'h30;
      2'd1:    return 8'h28;
      2'd2:    return 8'h0C;
      default: return 8'h06;
    endcase
  endfunction

  assign lcd_d    = lo ? cur[3:0] : cur[7:4];
  assign lcd_rs   = rs_q;
  assign lcd_e    = (st == S_PULSE);
  assign in_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_WAIT;
      cnt    <= CW'(START_CYC - 1);
      cur    <= 8'h00;
      rs_q   <= 1'b0;
      lo     <= 1'b0;
      single <= 1'b0;
      step   <= 3'd0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          cur    <= in_byte;
          rs_q   <= in_is_data;
          lo     <= 1'b0;
          single <= 1'b0;
          st     <= S_SETUP;
          cnt    <= CW'(SETUP_CYC - 1);
        end
        S_SETUP: if (cnt == '0) begin
          st  <= S_PULSE;
          cnt <= CW'(PULSE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_PULSE: if (cnt == '0) st <= S_HOLD;
                 else cnt <= cnt - 1'b1;
        S_HOLD: if (!lo && !single) begin
          lo  <= 1'b1;
          st  <= S_SETUP;
          cnt <= CW'(SETUP_CYC - 1);
        end else begin
          st  <= S_WAIT;
          cnt <= single ? CW'(BOOT_WAIT_CYC - 1) : CW'(WAIT_CYC - 1);
        end
        S_WAIT: if (cnt != '0) cnt <= cnt - 1'b1;
        else if (!step[2]) begin
          cur    <= boot_byte(step[1:0]);
          rs_q   <= 1'b0;
          lo     <= 1'b0;
          single <= (step == 3'd0);
          step   <= step + 1'b1;
          st     <= S_SETUP;
          cnt    <= CW'(SETUP_CYC - 1);
        end else st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd4_seq_chk.sv
module lcd4_seq_chk #(
  parameter int SETUP_CYC = 4,
  parameter int PULSE_CYC = 24
)(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] lcd_d,
  input logic       lcd_rs,
  input logic       lcd_e,
  input logic       in_valid,
  input logic       in_ready
);
  logic [3:0] pd;
  logic       prs;
  int         eq_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd <= '0; prs <= 1'b0; eq_cnt <= 0; hi_cnt <= 0;
    end else begin
      pd  <= lcd_d;
      prs <= lcd_rs;
      if ({lcd_rs, lcd_d} != {prs, pd}) eq_cnt <= 0;
      else if (eq_cnt < SETUP_CYC) eq_cnt <= eq_cnt + 1;
      if (!lcd_e) hi_cnt <= 0;
      else if (hi_cnt < PULSE_CYC) hi_cnt <= hi_cnt + 1;
    end
  end

  assert_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> (eq_cnt + 1 >= SETUP_CYC));
  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> (hi_cnt >= PULSE_CYC));
  assert_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> ($stable(lcd_d) && $stable(lcd_rs)));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> ($stable(lcd_d) && $stable(lcd_rs)));
  assert_ready_e_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !lcd_e);
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind lcd4_seq lcd4_seq_chk #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .lcd_d(lcd_d), .lcd_rs(lcd_rs), .lcd_e(lcd_e),
  .in_valid(in_valid), .in_ready(in_ready)
);

// File: tb/sim_lcd4_seq.sv
`timescale 1ns/1ps
module sim_lcd4_seq;
  localparam int SETUP = 2, PULSE = 3, WAITC = 5, BOOTW = 20, START = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_is_data = 1'b0, in_valid = 1'b0;
  logic in_ready, lcd_rs, lcd_e;
  logic [3:0] lcd_d;

  lcd4_seq #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .WAIT_CYC(WAITC),
             .BOOT_WAIT_CYC(BOOTW), .START_CYC(START)) u0 (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_is_data(in_is_data),
    .in_valid(in_valid), .in_ready(in_ready), .lcd_d(lcd_d), .lcd_rs(lcd_rs),
    .lcd_e(lcd_e));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [4:0] expq[$];
  int pushed = 0, seen = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [4:0] nib(input logic rs, input logic [3:0] d);
    return {rs, d};
  endfunction

  task automatic expect_byte(input logic rs, input logic [7:0] b);
    expq.push_back(nib(rs, b[7:4]));
    expq.push_back(nib(rs, b[3:0]));
    pushed += 2;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor, sampled away from the active edge
  logic pe = 1'b0, pr = 1'b0, prs = 1'b0;
  logic [3:0] pd = 4'h0;
  int lc = 0, hc = 0, since = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
    if (rst_n) begin
      since++;
      if (lcd_e && !pe) begin
        check(lc >= SETUP, "R5 setup cycles before E rise", lc, SETUP);
        if (seen == 1) check(since >= BOOTW, "R7 boot wait", since, BOOTW);
        hc = 0;
      end
      if (lcd_e) begin
        hc++;
        check(in_ready == 1'b0, "R8 ready while E high", in_ready, 0);
        if (pe) check({lcd_rs, lcd_d} == {prs, pd}, "R6 bus steady while E high",
                      {lcd_rs, lcd_d}, {prs, pd});
      end
      if (!lcd_e && pe) begin
        check(hc >= PULSE, "R6 E pulse width", hc, PULSE);
        check({lcd_rs, lcd_d} == {prs, pd}, "R6 bus held at E fall",
              {lcd_rs, lcd_d}, {prs, pd});
        if (expq.size() == 0)
          check(1'b0, "R9 unexpected nibble", {lcd_rs, lcd_d}, 0);
        else begin
          logic [4:0] e;
          e = expq.pop_front();
          check({lcd_rs, lcd_d} == e, seen < 7 ? "R2 init nibble" : "R3/R4 nibble",
                {lcd_rs, lcd_d}, e);
        end
        seen++;
        since = 0;
      end
      if (in_ready && !pr && seen > 7)
        check(since >= WAITC, "R8 wait after byte", since, WAITC);
      if (!lcd_e) lc = ({lcd_rs, lcd_d} == {prs, pd}) ? lc + 1 : 1;
    end
    pe = lcd_e; pr = in_ready; pd = lcd_d; prs = lcd_rs;
  end

  task automatic send(input logic rs, input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_byte = b; in_is_data = rs; in_valid = 1'b1;
    expect_byte(rs, b);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R10 ready drops after accept", in_ready, 0);
  endtask

  task automatic drain;
    repeat (2) @(negedge clk);
    while (!in_ready || lcd_e) @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    check(lcd_e == 1'b0, "R1 E low in reset", lcd_e, 0);
    check(in_ready == 1'b0, "R1 ready low in reset", in_ready, 0);
    expq.push_back(nib(1'b0, 4'h3));
    expect_byte(1'b0, 8'h28);
    expect_byte(1'b0, 8'h0C);
    expect_byte(1'b0, 8'h06);
    pushed++;
    rst_n = 1'b1;
    repeat (START - 1) begin
      @(negedge clk);
      check(lcd_e == 1'b0 && in_ready == 1'b0, "R1 quiet start interval", {lcd_e, in_ready}, 0);
    end
    while (!in_ready) begin
      @(negedge clk);
      if (!in_ready && seen >= 7 && lcd_e)
        check(1'b0, "R2 extra strobe during init", seen, 7);
    end
    check(seen == 7, "R2 init nibble count", seen, 7);

    // directed corners
    send(1'b0, 8'h01);
    send(1'b1, 8'hFF);
    send(1'b1, 8'h00);
    send(1'b0, 8'hF0);
    // R9: offer a byte while busy; it must not appear
    @(negedge clk);
    check(in_ready == 1'b0, "R9 block busy during junk offer", in_ready, 0);
    in_byte = 8'hA5; in_is_data = 1'b1; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    drain();
    check(seen == pushed, "R9 no nibble from ignored byte", seen, pushed);

    // random traffic
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      send(1'($urandom), b);
      repeat ($urandom % 4) @(negedge clk);
    end
    drain();
    check(seen == pushed, "R3 all nibbles delivered", seen, pushed);
    check(expq.size() == 0, "R4 expected stream drained", expq.size(), 0);
    finish_run();
  end
endmodule